// File: doc/BRIEF.md
# Angle-Synchronous Engine Event Generator

This block raises digital outputs at programmed crank angles instead of at programmed times. It keeps an angle counter in sub-degree steps that covers a full four-stroke cycle of 720 degrees. A resolution input selects 10 or 100 steps per degree. In the external-source mode the counter follows a position pulse input that arrives once per degree. The block measures the spacing of those pulses in clock cycles and fills the gap between them with evenly timed sub-steps. An index pulse re-anchors the counter, and a cam level tells the two crank turns apart. In the internal-source mode the counter runs from a simulated engine whose sub-step period, in clock cycles, the host rewrites as the speed changes.

Each of the event channels holds a start and an end angle. The host loads these angles while the block is stopped. The channel output is high while the angle lies inside its window. The block also regenerates position, index and cam signals from its own angle, so downstream logic sees a clean reference in either mode. All outputs are registered and change on the same clock edge as the angle.

Top module: `crank_event_gen`

## Requirements
- R1: After reset, every event output and the regenerated position, index and cam outputs are low.
- R2: A channel with start < end drives its output high exactly while start <= angle < end. The output is registered in the same cycle the angle takes its new value.
- R3: A channel with start > end is high while angle >= start or angle < end, so the window wraps through zero. A channel with start == end is never high.
- R4: In external mode the angle advances one sub-step every floor(G / K) clock cycles. G is the measured number of cycles between the last two position rising edges. K is 10 when `fine_res` is 0 and 100 when it is 1. A step period of 0 advances nothing.
- R5: In external mode, interpolation stops at the last sub-step of the current degree. A position rising edge moves the angle to the next whole degree (next multiple of K) and restarts sub-step timing.
- R6: In external mode an index rising edge sets the angle to 0 when `cam_in` is low and to 360*K when it is high. The index edge takes priority over a position edge in the same cycle.
- R7: In internal mode the angle advances one sub-step every P cycles, where P is the active period. A value written on `per_we` becomes active at the next sub-step boundary, or immediately while stopped. The position and index inputs have no effect in this mode.
- R8: `pos_out` pulses for one cycle when the angle is moved onto a whole degree. `idx_out` pulses with it when that degree is 0 or 360. `cam_out` is high while the angle is at least 360*K.
- R9: Channel configuration writes are accepted only while `run` is low. Writes made while running leave the window unchanged.
- R10: While `run` is low the angle and sub-step timing are cleared and all outputs go low on the next edge.
- R11: The angle counts modulo 720*K: one step past 720*K-1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables angle tracking and outputs |
| src_int | input | 1 | 1 = simulated engine, 0 = external pulses |
| fine_res | input | 1 | 0 = 10 steps per degree, 1 = 100 |
| cfg_we | input | 1 | Window write strobe (accepted only when stopped) |
| cfg_ch | input | CHW | Channel selected by a window write |
| cfg_start | input | ANGW | Window start angle in sub-steps |
| cfg_end | input | ANGW | Window end angle in sub-steps (exclusive) |
| per_we | input | 1 | Simulated sub-step period write strobe |
| per_val | input | PERW | Simulated sub-step period in clock cycles |
| pos_in | input | 1 | External once-per-degree position pulse |
| idx_in | input | 1 | External index pulse |
| cam_in | input | 1 | External cam level |
| evt_out | output | NCH | Event channel outputs |
| pos_out | output | 1 | Regenerated position pulse |
| idx_out | output | 1 | Regenerated index pulse |
| cam_out | output | 1 | Regenerated cam level |

## Verification
A wrong angle shows on the ports in the same cycle it occurs. Every window edge, and every regenerated position and index pulse, then appears one or more cycles early or late. The bench compares all outputs with a behavioural model on every clock. An interpolation error is therefore caught within one sub-step period of the cycle where the model and the design diverge. A wrong measured pulse spacing or a wrong period hand-over shows up within the next sub-step. A missing hold at the last sub-step of a degree shows up before the following position pulse.

// File: rtl/crank_evt_pkg.sv
package crank_evt_pkg;
  localparam int unsigned CYCLE_DEG = 720;
  localparam int unsigned STEPS_LO  = 10;
  localparam int unsigned STEPS_HI  = 100;
  localparam int unsigned ANGW      = $clog2(CYCLE_DEG * STEPS_HI);
  localparam int unsigned SUBW      = $clog2(STEPS_HI + 1);

  typedef logic [ANGW-1:0] ang_t;
  typedef logic [SUBW-1:0] sub_t;

  // sub-steps per degree
  function automatic sub_t steps_per_deg(input logic fine);
    return fine ? sub_t'(STEPS_HI) : sub_t'(STEPS_LO);
  endfunction

  // sub-steps in one 720 degree cycle
  function automatic ang_t cycle_len(input logic fine);
    return fine ? ang_t'(CYCLE_DEG * STEPS_HI) : ang_t'(CYCLE_DEG * STEPS_LO);
  endfunction

  function automatic ang_t second_turn(input logic fine);
    return fine ? ang_t'(CYCLE_DEG * STEPS_HI / 2) : ang_t'(CYCLE_DEG * STEPS_LO / 2);
  endfunction

  // window membership with wrap-through-zero support
  function automatic logic in_window(input ang_t a, input ang_t s, input ang_t e);
    if (s == e)     return 1'b0;
    else if (s < e) return (a >= s) && (a < e);
    else            return (a >= s) || (a < e);
  endfunction
endpackage

// File: rtl/crank_pulse_meas.sv
module crank_pulse_meas #(
  parameter int PERW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            pos_in,
  input  logic            idx_in,
  output logic            pos_edge,
  output logic            idx_edge,
  output logic [PERW-1:0] meas_q
);
  logic            pos_q, idx_q;
  logic [PERW-1:0] gap_q;

  assign pos_edge = pos_in & ~pos_q;
  assign idx_edge = idx_in & ~idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= 1'b0;
      idx_q  <= 1'b0;
      gap_q  <= '0;
      meas_q <= '0;
    end else begin
      pos_q <= pos_in;
      idx_q <= idx_in;
      if (!run) begin
        gap_q  <= '0;
        meas_q <= '0;
      end else if (pos_edge) begin
        meas_q <= gap_q;
        gap_q  <= PERW'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/crank_angle_track.sv
module crank_angle_track
  import crank_evt_pkg::*;
#(
  parameter int PERW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_int,
  input  logic            fine_res,
  input  logic            pos_edge,
  input  logic            idx_edge,
  input  logic            cam_in,
  input  logic [PERW-1:0] meas_q,
  input  logic            per_we,
  input  logic [PERW-1:0] per_val,
  output ang_t            ang_nx,
  output sub_t            sub_nx,
  output ang_t            angle_q,
  output sub_t            sub_q,
  output logic            moved
);
  localparam int PADW = ANGW + 1 - SUBW;

  logic [PERW-1:0] tick_q, tick_nx, per_act, act_nx, per_pend, step_ext, per_use;
  sub_t            ratio;
  ang_t            full, half, snap;
  logic [ANGW:0]   snap_w;

  assign ratio    = steps_per_deg(fine_res);
  assign full     = cycle_len(fine_res);
  assign half     = second_turn(fine_res);
  assign step_ext = fine_res ? meas_q / PERW'(STEPS_HI) : meas_q / PERW'(STEPS_LO);
  assign per_use  = src_int ? per_act : step_ext;
  assign snap_w   = {1'b0, angle_q} - {{PADW{1'b0}}, sub_q} + {{PADW{1'b0}}, ratio};
  assign snap     = (snap_w >= {1'b0, full}) ? ANGW'(snap_w - {1'b0, full}) : ANGW'(snap_w);

  always_comb begin
    ang_nx  = angle_q;
    sub_nx  = sub_q;
    tick_nx = tick_q + 1'b1;
    act_nx  = per_act;
    moved   = 1'b0;
    if (!run) begin
      ang_nx  = '0;
      sub_nx  = '0;
      tick_nx = '0;
      act_nx  = per_pend;
    end else if (!src_int && idx_edge) begin
      ang_nx  = cam_in ? half : '0;
      sub_nx  = '0;
      tick_nx = '0;
      moved   = 1'b1;
    end else if (!src_int && pos_edge) begin
      ang_nx  = snap;
      sub_nx  = '0;
      tick_nx = '0;
      moved   = 1'b1;
    end else if (per_use == '0) begin
      tick_nx = '0;
      if (src_int) act_nx = per_pend;
    end else if (tick_q >= per_use - 1'b1) begin
      tick_nx = '0;
      if (src_int) act_nx = per_pend;
      if (src_int || (sub_q < ratio - 1'b1)) begin
        sub_nx = (sub_q == ratio - 1'b1) ? '0 : sub_q + 1'b1;
        ang_nx = (angle_q == full - 1'b1) ? '0 : angle_q + 1'b1;
        moved  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angle_q  <= '0;
      sub_q    <= '0;
      tick_q   <= '0;
      per_act  <= '0;
      per_pend <= '0;
    end else begin
      angle_q <= ang_nx;
      sub_q   <= sub_nx;
      tick_q  <= tick_nx;
      per_act <= act_nx;
      if (per_we) per_pend <= per_val;
    end
  end
endmodule

// File: rtl/crank_evt_chan.sv
module crank_evt_chan
  import crank_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  ang_t wr_start,
  input  ang_t wr_end,
  input  logic run,
  input  ang_t ang_nx,
  output logic evt
);
  ang_t start_q, end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      evt     <= 1'b0;
    end else begin
      evt <= run && in_window(ang_nx, start_q, end_q);
      if (wr_en) begin
        start_q <= wr_start;
        end_q   <= wr_end;
      end
    end
  end
endmodule

// File: rtl/crank_event_gen.sv
module crank_event_gen
  import crank_evt_pkg::*;
#(
  parameter  int NCH  = 16,
  parameter  int PERW = 16,
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            src_int,
  input  logic            fine_res,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [ANGW-1:0] cfg_start,
  input  logic [ANGW-1:0] cfg_end,
  input  logic            per_we,
  input  logic [PERW-1:0] per_val,
  input  logic            pos_in,
  input  logic            idx_in,
  input  logic            cam_in,
  output logic [NCH-1:0]  evt_out,
  output logic            pos_out,
  output logic            idx_out,
  output logic            cam_out
);
  logic            pos_edge, idx_edge, moved;
  logic [PERW-1:0] meas_q;
  ang_t            ang_nx, angle_q, half_w;
  sub_t            sub_nx, sub_q;

  assign half_w = second_turn(fine_res);

  crank_pulse_meas #(.PERW(PERW)) u_meas (
    .clk(clk), .rst_n(rst_n), .run(run), .pos_in(pos_in), .idx_in(idx_in),
    .pos_edge(pos_edge), .idx_edge(idx_edge), .meas_q(meas_q)
  );

  crank_angle_track #(.PERW(PERW)) u_track (
    .clk(clk), .rst_n(rst_n), .run(run), .src_int(src_int), .fine_res(fine_res),
    .pos_edge(pos_edge), .idx_edge(idx_edge), .cam_in(cam_in), .meas_q(meas_q),
    .per_we(per_we), .per_val(per_val), .ang_nx(ang_nx), .sub_nx(sub_nx),
    .angle_q(angle_q), .sub_q(sub_q), .moved(moved)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    crank_evt_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we && !run && (cfg_ch == CHW'(g))),
      .wr_start(cfg_start), .wr_end(cfg_end),
      .run(run), .ang_nx(ang_nx), .evt(evt_out[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_out <= 1'b0;
      idx_out <= 1'b0;
      cam_out <= 1'b0;
    end else begin
      pos_out <= moved && (sub_nx == '0);
      idx_out <= moved && (sub_nx == '0) && ((ang_nx == '0) || (ang_nx == half_w));
      cam_out <= run && (ang_nx >= half_w);
    end
  end
endmodule

// File: rtl/crank_event_gen_chk.sv
module crank_event_gen_chk
  import crank_evt_pkg::*;
#(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic           src_int,
  input logic           fine_res,
  input logic           idx_edge,
  input ang_t           angle_q,
  input sub_t           sub_q,
  input logic [NCH-1:0] evt_out,
  input logic           pos_out,
  input logic           idx_out,
  input logic           cam_out
);
  // R5
  sub_in_degree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q < steps_per_deg(fine_res));

  // R11
  angle_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    angle_q < cycle_len(fine_res));

  // R6
  index_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !src_int && idx_edge) |=> (angle_q == '0 || angle_q == second_turn(fine_res)));

  // R10
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (evt_out == '0 && !pos_out && !idx_out && !cam_out));

  // R8
  index_on_degree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_out |-> pos_out);
endmodule

bind crank_event_gen crank_event_gen_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .src_int(src_int), .fine_res(fine_res),
  .idx_edge(idx_edge), .angle_q(angle_q), .sub_q(sub_q), .evt_out(evt_out),
  .pos_out(pos_out), .idx_out(idx_out), .cam_out(cam_out)
);

// File: tb/crank_event_gen_bench.sv
`timescale 1ns/100ps
module crank_event_gen_bench;
  localparam int NCH = 16;
  localparam int PERW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, src_int = 0, fine_res = 0, cfg_we = 0, per_we = 0;
  logic pos_in = 0, idx_in = 0, cam_in = 0;
  logic [3:0]  cfg_ch = '0;
  logic [16:0] cfg_start = '0, cfg_end = '0;
  logic [PERW-1:0] per_val = '0;
  logic [NCH-1:0] evt_out;
  logic pos_out, idx_out, cam_out;

  int checks = 0, fails = 0;
  bit done = 0, comparing = 0, ch2_seen = 0;
  string cur_req = "R2";

  always #2.5 clk = ~clk;

  crank_event_gen u_crank_event_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .src_int(src_int), .fine_res(fine_res),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_start(cfg_start), .cfg_end(cfg_end),
    .per_we(per_we), .per_val(per_val), .pos_in(pos_in), .idx_in(idx_in),
    .cam_in(cam_in), .evt_out(evt_out), .pos_out(pos_out), .idx_out(idx_out),
    .cam_out(cam_out)
  );

  // behavioural reference model
  int m_ang, m_tick, m_act, m_pend, m_gap, m_meas;
  int m_ws [NCH];
  int m_we [NCH];
  bit m_ppos, m_pidx;
  logic [NCH-1:0] x_evt;
  logic x_pos, x_idx, x_cam;

  function automatic bit inside_win(int a, int s, int e);
    if (s < e) return a >= s && a < e;
    if (s > e) return !(a >= e && a < s);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ang = 0; m_tick = 0; m_act = 0; m_pend = 0; m_gap = 0; m_meas = 0;
      m_ppos = 0; m_pidx = 0;
      foreach (m_ws[i]) begin m_ws[i] = 0; m_we[i] = 0; end
      x_evt = '0; x_pos = 0; x_idx = 0; x_cam = 0;
    end else begin
      int k, full, half, per;
      bit pe, ie, mv;
      k = fine_res ? 100 : 10;
      full = 720 * k;
      half = 360 * k;
      pe = pos_in && !m_ppos;
      ie = idx_in && !m_pidx;
      per = src_int ? m_act : (m_meas / k);
      mv = 0;
      if (!run) begin
        m_ang = 0; m_tick = 0; m_act = m_pend;
      end else if (!src_int && ie) begin
        m_ang = cam_in ? half : 0; m_tick = 0; mv = 1;
      end else if (!src_int && pe) begin
        m_ang = ((m_ang / k + 1) * k) % full; m_tick = 0; mv = 1;
      end else if (per == 0) begin
        m_tick = 0;
        if (src_int) m_act = m_pend;
      end else if (m_tick + 1 >= per) begin
        m_tick = 0;
        if (src_int) m_act = m_pend;
        if (src_int || (m_ang % k) != k - 1) begin
          m_ang = (m_ang + 1) % full; mv = 1;
        end
      end else m_tick++;
      if (!run) begin m_gap = 0; m_meas = 0; end
      else if (pe) begin m_meas = m_gap; m_gap = 1; end
      else if (m_gap < 65535) m_gap++;
      x_pos = mv && (m_ang % k == 0);
      x_idx = x_pos && (m_ang == 0 || m_ang == half);
      x_cam = run && m_ang >= half;
      for (int i = 0; i < NCH; i++) x_evt[i] = run && inside_win(m_ang, m_ws[i], m_we[i]);
      if (cfg_we && !run) begin m_ws[cfg_ch] = cfg_start; m_we[cfg_ch] = cfg_end; end
      if (per_we) m_pend = per_val;
      m_ppos = pos_in;
      m_pidx = idx_in;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && comparing) begin
      if (evt_out[2]) ch2_seen = 1;
      check(evt_out === x_evt, cur_req, "evt_out", int'(evt_out), int'(x_evt));
      check({pos_out, idx_out, cam_out} === {x_pos, x_idx, x_cam}, "R8",
            "pos/idx/cam", int'({pos_out, idx_out, cam_out}), int'({x_pos, x_idx, x_cam}));
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pos_pulse(int gap);
    @(negedge clk) pos_in = 1;
    @(negedge clk) pos_in = 0;
    wait_cyc(gap - 2);
  endtask

  task automatic idx_pulse(bit with_pos);
    @(negedge clk) begin idx_in = 1; pos_in = with_pos; end
    @(negedge clk) begin idx_in = 0; pos_in = 0; end
  endtask

  task automatic set_win(int ch, int s, int e);
    @(negedge clk) begin cfg_we = 1; cfg_ch = 4'(ch); cfg_start = 17'(s); cfg_end = 17'(e); end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic set_per(int p);
    @(negedge clk) begin per_we = 1; per_val = PERW'(p); end
    @(negedge clk) per_we = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    // R1: reset state
    check(evt_out == '0 && !pos_out && !idx_out && !cam_out, "R1", "outputs in reset",
          int'({evt_out, pos_out, idx_out, cam_out}), 0);
    @(negedge clk) rst_n = 1;
    comparing = 1;
    wait_cyc(2);
    check(evt_out == '0 && !cam_out, "R1", "outputs after reset", int'(evt_out), 0);

    set_win(0, 5, 15);
    set_win(1, 7190, 25);
    set_win(2, 40, 40);
    set_win(3, 3600, 3620);
    set_win(4, 100, 110);
    set_win(5, 300, 350);
    set_per(3);

    // R2 then R4: external pulses, 100 cycles apart
    @(negedge clk) run = 1;
    cur_req = "R6";
    idx_pulse(0);
    cur_req = "R2";
    for (int i = 0; i < 3; i++) pos_pulse(100);
    cur_req = "R4";
    for (int i = 0; i < 7; i++) pos_pulse(100);
    // R5: slower pulses force a hold at the last sub-step
    cur_req = "R5";
    for (int i = 0; i < 3; i++) pos_pulse(200);

    // R9: write while running must be ignored
    cur_req = "R9";
    set_win(4, 0, 7000);
    wait_cyc(2);
    check(evt_out[4] === 1'b0, "R9", "evt_out[4] after write while running", int'(evt_out[4]), 0);
    for (int i = 0; i < 3; i++) pos_pulse(100);

    // R6: index with cam high lands on second turn
    cur_req = "R6";
    @(negedge clk) cam_in = 1;
    idx_pulse(0);
    check(cam_out === 1'b1 && evt_out[3] === 1'b1, "R6", "cam_out,evt_out[3] after index",
          int'({cam_out, evt_out[3]}), 3);
    for (int i = 0; i < 3; i++) pos_pulse(100);
    @(negedge clk) cam_in = 0;
    idx_pulse(1);
    check(evt_out[1] === 1'b1 && pos_out && idx_out && !cam_out, "R6",
          "index beats position", int'({evt_out[1], pos_out, idx_out, cam_out}), 14);
    for (int i = 0; i < 2; i++) pos_pulse(100);

    // R10: stop clears everything
    cur_req = "R10";
    @(negedge clk) run = 0;
    wait_cyc(3);
    check(evt_out == '0 && !cam_out && !pos_out, "R10", "outputs while stopped",
          int'({evt_out, cam_out}), 0);

    // R4 with fine resolution
    cur_req = "R4";
    @(negedge clk) begin fine_res = 1; run = 1; end
    for (int i = 0; i < 6; i++) pos_pulse(200);
    @(negedge clk) run = 0;
    wait_cyc(2);

    // R7: simulated engine, period change mid-run
    cur_req = "R7";
    @(negedge clk) begin fine_res = 0; src_int = 1; end
    wait_cyc(2);
    @(negedge clk) run = 1;
    for (int i = 0; i < 3; i++) pos_pulse(50);
    idx_pulse(0);
    wait_cyc(100);
    set_per(1);
    // R11: wrap around the full cycle
    cur_req = "R11";
    wait_cyc(7200);
    cur_req = "R3";
    wait_cyc(300);
    check(ch2_seen == 0, "R3", "empty window ever high", int'(ch2_seen), 0);
    @(negedge clk) run = 0;
    wait_cyc(3);
    comparing = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule